// File: doc/BRIEF.md
# Tachometer Speed Discriminator with Lock Flag

This block judges the rotation speed of a motor from its squared tachometer pulse train. It times each tachometer period by counting ticks of a divided-down reference clock. It then compares the latest period with a fixed target that is tied to the reference clock frequency. Every second tachometer period it gives a verdict: a direction bit that asks the speed loop to speed up or slow down, and an active-low flag that is low while the speed lies within a symmetric tolerance band around the target.

The tachometer input is asynchronous to the reference clock. It passes through a synchronizer before its rising edges are used. With the default parameters the reference clock is divided by 16, and a nominal period spans 512 ticks. The target tachometer frequency is therefore the reference frequency divided by 8192. The tolerance band is one sixteenth of the target count on either side. Reset is synchronous and active high.

Top module: `fg_speed_discriminator`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `dout` is 0, `ld_n` is 1 and `err_valid` is 0.
- R2: The measured count of a tachometer period is the number of prescaler ticks (one tick every `DIV` clock cycles) between two successive synchronized rising edges of `fg`. A period of exactly `DIV*k` clock cycles yields count k.
- R3: The first rising edge of `fg` after reset only starts the count, and it produces no `err_valid` pulse.
- R4: After the first edge, `err_valid` pulses high for exactly one clock cycle on every second synchronized rising edge, and never on the others.
- R5: At a decision `dout` becomes 1 when the measured count is greater than `NOMINAL` (the period is too long, so the motor must accelerate). Otherwise it becomes 0; a count equal to `NOMINAL` gives 0.
- R6: At a decision `ld_n` becomes 0 when the count lies in `NOMINAL - NOMINAL/16` to `NOMINAL + NOMINAL/16` inclusive, and 1 otherwise.
- R7: The period count saturates at `2**CNT_W - 1`. A saturated count is judged too slow (`dout` = 1) and not locked (`ld_n` = 1).
- R8: `dout` and `ld_n` change only in the cycle where `err_valid` is high, and hold their values between decisions.
- R9: A decision uses only the period that ends at the deciding edge. The period just before it, which is the first of the pair, has no effect on `dout` or `ld_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (crystal) clock |
| rst | input | 1 | Synchronous reset, active high |
| fg | input | 1 | Squared tachometer pulse train, asynchronous |
| dout | output | 1 | 1 = accelerate, 0 = decelerate |
| err_valid | output | 1 | One-cycle strobe marking a new decision |
| ld_n | output | 1 | Speed lock flag, active low |

## Verification
The bench sweeps the measured count from well below the band to beyond saturation. It hits the band edges, the exact target, the value one count on each side of the band, and the saturation value itself. A band compare that is off by one, or that uses the wrong inequality, shows up as a wrong `ld_n` at 29/30/34/35 or a wrong `dout` at 32/33. A counter that wraps instead of saturating reports fast and locked speeds for long periods. The first period of each pair is always chosen with the opposite verdict. A design that decides on every edge, or that averages the pair, therefore reports the wrong verdict or an extra `err_valid` pulse. The same pulse count also catches a design that decides on the first edge after reset.

// File: rtl/fgd_pkg.sv
package fgd_pkg;

  // Position within the two-period decision cycle
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // no edge seen since reset
    PH_HALF = 2'd1,  // one period of the pair running
    PH_FULL = 2'd2   // next edge closes the pair and decides
  } phase_e;

  typedef struct packed {
    logic accel;
    logic locked;
  } verdict_t;

endpackage

// File: rtl/fgd_edge_sync.sv
module fgd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/fgd_prescaler.sv
module fgd_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || cnt_q == LAST) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
      end

      assign tick = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/fgd_period_counter.sv
module fgd_period_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  output logic [CNT_W-1:0] meas
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  // Count including a tick that lands in the closing cycle, clamped at TOP
  always_comb begin
    sum  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, tick};
    meas = sum[CNT_W] ? TOP : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else                cnt_q <= meas;
  end

endmodule

// File: rtl/fgd_judge.sv
module fgd_judge
  import fgd_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int NOMINAL = 512,
  parameter int WIN     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_in,
  input  logic [CNT_W-1:0] meas,
  output logic             dout,
  output logic             ld_n,
  output logic             err_valid
);

  localparam logic [CNT_W-1:0] TOP   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] NOM_C = CNT_W'(NOMINAL);
  localparam logic [CNT_W-1:0] LO_C  = CNT_W'(NOMINAL - WIN);
  localparam logic [CNT_W-1:0] HI_C  = CNT_W'(NOMINAL + WIN);

  phase_e   ph_q;
  verdict_t vd;

  always_comb begin
    vd.accel  = (meas > NOM_C) || (meas == TOP);
    vd.locked = (meas >= LO_C) && (meas <= HI_C) && (meas != TOP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      dout      <= 1'b0;
      ld_n      <= 1'b1;
      err_valid <= 1'b0;
    end else begin
      err_valid <= 1'b0;
      if (edge_in) begin
        case (ph_q)
          PH_IDLE: ph_q <= PH_HALF;
          PH_HALF: ph_q <= PH_FULL;
          PH_FULL: begin
            ph_q      <= PH_HALF;
            dout      <= vd.accel;
            ld_n      <= ~vd.locked;
            err_valid <= 1'b1;
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/fg_speed_discriminator.sv
module fg_speed_discriminator #(
  parameter int DIV         = 16,
  parameter int NOMINAL     = 512,
  parameter int CNT_W       = 10,
  parameter int WIN_SHIFT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fg,
  output logic dout,
  output logic err_valid,
  output logic ld_n
);

  localparam int WIN = NOMINAL >> WIN_SHIFT;

  logic             fg_rise;
  logic             tick;
  logic [CNT_W-1:0] meas;

  fgd_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .din (fg),
    .rise(fg_rise)
  );

  fgd_prescaler #(.DIV(DIV)) pre_i (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  fgd_period_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .restart(fg_rise),
    .meas   (meas)
  );

  fgd_judge #(.CNT_W(CNT_W), .NOMINAL(NOMINAL), .WIN(WIN)) judge_i (
    .clk      (clk),
    .rst      (rst),
    .edge_in  (fg_rise),
    .meas     (meas),
    .dout     (dout),
    .ld_n     (ld_n),
    .err_valid(err_valid)
  );

endmodule

// File: rtl/fgd_checker.sv
module fgd_checker #(
  parameter int CNT_W   = 10,
  parameter int NOMINAL = 512
) (
  input logic             clk,
  input logic             rst,
  input logic             fg_rise,
  input logic [CNT_W-1:0] meas,
  input logic             dout,
  input logic             ld_n,
  input logic             err_valid
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> !err_valid);

  // R4
  strobe_from_edge_chk: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> $past(fg_rise));

  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !err_valid |-> ($stable(dout) && $stable(ld_n)));

  // R7
  saturated_slow_chk: assert property (@(posedge clk) disable iff (rst)
    (err_valid && $past(meas) == TOP) |-> (dout && ld_n));

  // R5
  direction_chk: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (dout == ($past(meas) > CNT_W'(NOMINAL))));

endmodule

bind fg_speed_discriminator fgd_checker #(.CNT_W(CNT_W), .NOMINAL(NOMINAL)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .fg_rise  (fg_rise),
  .meas     (meas),
  .dout     (dout),
  .ld_n     (ld_n),
  .err_valid(err_valid)
);

// File: tb/fg_speed_discriminator_tb.sv
module fg_speed_discriminator_tb_top;

  localparam int DIV   = 2;
  localparam int NOM   = 32;
  localparam int CW    = 6;
  localparam int TOPV  = (1 << CW) - 1;
  localparam int LO    = NOM - NOM / 16;
  localparam int HI    = NOM + NOM / 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fg  = 1'b0;
  logic dout, err_valid, ld_n;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int doubles = 0;
  int cap_dout = 0;
  int cap_ld = 1;
  logic prev_ev = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fg_speed_discriminator #(.DIV(DIV), .NOMINAL(NOM), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .fg(fg),
    .dout(dout), .err_valid(err_valid), .ld_n(ld_n)
  );

  always @(negedge clk) begin
    if (rst) begin
      prev_ev = 1'b0;
    end else begin
      if (err_valid) begin
        pulses++;
        cap_dout = int'(dout);
        cap_ld = int'(ld_n);
        if (prev_ev) doubles++;
      end
      prev_ev = err_valid;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic period(input int lo, input int hi);
    fg = 1'b0;
    wait_clk(lo);
    fg = 1'b1;
    wait_clk(hi);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    fg = 1'b0;
    wait_clk(4);
    chk("R1 dout in reset", int'(dout), 0);
    chk("R1 ld_n in reset", int'(ld_n), 1);
    chk("R1 err_valid in reset", int'(err_valid), 0);
    rst = 1'b0;
    wait_clk(1);
    chk("R1 err_valid after release", int'(err_valid), 0);
  endtask

  // One pair: a decoy period with the opposite verdict, then a period of c ticks
  task automatic run_case(input int c);
    int m, p0, junk;
    bit lk;
    m = (c > TOPV) ? TOPV : c;
    lk = (m >= LO) && (m <= HI) && (m != TOPV);
    // decoy count = (20 + junk)/2 : 32 (locked) or 60 (unlocked)
    junk = lk ? 100 : 44;
    p0 = pulses;
    period(junk, c);
    chk($sformatf("R9 no decision on first edge of pair c=%0d", c), pulses - p0, 0);
    period(c, 20);
    chk($sformatf("R4 one strobe per pair c=%0d", c), pulses - p0, 1);
    chk($sformatf("R2 R5 R7 dout c=%0d", c), cap_dout, (m > NOM || m == TOPV) ? 1 : 0);
    chk($sformatf("R2 R6 R7 R9 ld_n c=%0d", c), cap_ld, lk ? 0 : 1);
    chk($sformatf("R8 dout held c=%0d", c), int'(dout), cap_dout);
    chk($sformatf("R8 ld_n held c=%0d", c), int'(ld_n), cap_ld);
  endtask

  initial begin
    do_reset();
    period(10, 20);
    chk("R3 no strobe on first edge", pulses, 0);
    for (int c = 20; c <= 70; c++) run_case(c);
    chk("R4 strobe width one cycle", doubles, 0);

    do_reset();
    pulses = 0;
    period(10, 20);
    chk("R3 no strobe on first edge after second reset", pulses, 0);
    run_case(NOM);
    run_case(HI + 1);
    chk("R4 strobe width one cycle after reset", doubles, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule